// File: doc/BRIEF.md
# Multi-Port Typed Issue Selector

This block decides, within a single cycle, which waiting issue-queue entries go to which execution port. Every queue slot presents a request bit (its operands are ready) and a small functional-unit type code. Every port presents a mask of the type codes its unit can execute and an available bit that its unit drops while it cannot take new work, for example an unpipelined divider in the middle of an operation.

The ports are served in a fixed chain. Port 0 goes first. Each port picks the lowest-numbered slot that is requesting, carries a type the port accepts and has not already been claimed by a port earlier in the chain. Each port reports a one-hot grant vector, a valid bit and the binary index of its chosen slot. The queue receives a per-slot issued vector that merges all grants, so it can remove those entries. The path is purely combinational, so outputs follow the inputs in the same cycle.

Top module: `typed_issue_select`

## Requirements
- R1: For every port the grant vector has at most one bit set, the port's valid bit is 1 exactly when a bit is set, and the index output equals the position of that bit.
- R2: Among the slots eligible for a port, the one with the lowest index is granted. Slot 0 has the highest priority.
- R3: A port grants slot s only when bit `slot_type[s]` of that port's type mask is 1. Type code t is mask bit t, and each port's mask occupies `2**TYPE_W` consecutive bits, port 0 lowest.
- R4: Ports are evaluated in order 0, 1, 2, ... A slot granted by a port is not eligible for any later port in the same cycle, so the next-lowest eligible slot goes to the later port.
- R5: A port whose available bit is 0 grants nothing. The slots it would have taken remain eligible for later ports.
- R6: A slot whose request bit is 0 is never granted by any port.
- R7: `slot_issued` is the bitwise OR of all port grants, and no slot is granted by more than one port.
- R8: The outputs depend only on the current inputs, with no register on the path, so a change is visible in the same cycle.
- R9: A port with no eligible slot drives its grant to all zeros, its valid bit to 0 and its index to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| slot_req | input | N_SLOTS | Per-slot ready request |
| slot_type | input | N_SLOTS*TYPE_W | Per-slot unit type code, slot 0 in the low bits |
| port_type_mask | input | N_PORTS*2**TYPE_W | Per-port accepted-type bitmap, port 0 in the low bits |
| port_avail | input | N_PORTS | Per-port unit available |
| port_grant | output | N_PORTS*N_SLOTS | One-hot grant per port, port 0 in the low bits |
| port_valid | output | N_PORTS | Port granted a slot this cycle |
| port_idx | output | N_PORTS*IDX_W | Index of granted slot per port |
| slot_issued | output | N_SLOTS | Slots granted by any port |

## Verification
Directed patterns each separate one rule from the others:
- All slots requesting with every port accepting every type shows the cascade handing out slots 0, 1 and 2 in port order.
- A floating-point-only type placed on slot 0 shows the type filter skipping that slot for integer ports.
- Dropping port 0's available bit shows port 1 taking slot 0.
- Sparse high-index requests, and types that no port accepts, check the lowest-index choice and the idle outputs.

A long run of random requests, types, masks and available bits, compared against an independent model, checks the merged issued vector and the no-double-grant rule over many overlaps.

// File: rtl/typed_issue_select_pkg.sv
// Package: shared helpers for the typed issue selector.
// Assumes: widths are small compile-time constants.
package typed_issue_select_pkg;
    // Width of a binary index for n items, never less than one bit.
    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/issel_prio_enc.sv
// Module: fixed-priority encoder, lowest set bit wins.
// Assumes: WIDTH >= 1; output index is zero when nothing is set.
module issel_prio_enc
    import typed_issue_select_pkg::*;
#(
    parameter int WIDTH = 8,
    localparam int IW   = idx_width(WIDTH)
) (
    input  logic [WIDTH-1:0] in_vec,
    output logic [WIDTH-1:0] onehot,
    output logic             found,
    output logic [IW-1:0]    index
);
    // Scan from the top down so the lowest set bit is the last write.
    always_comb begin
        onehot = '0;
        found  = 1'b0;
        index  = '0;
        for (int i = WIDTH - 1; i >= 0; i--) begin
            if (in_vec[i]) begin
                onehot = '0;
                onehot[i] = 1'b1;
                found  = 1'b1;
                index  = IW'(i);
            end
        end
    end
endmodule

// File: rtl/issel_port_stage.sv
// Module: one port of the cascade: filter slots by type, availability and
// earlier claims, then pick one and pass the updated claim vector on.
// Assumes: type_mask is indexed by type code.
module issel_port_stage
    import typed_issue_select_pkg::*;
#(
    parameter int N_SLOTS = 8,
    parameter int TYPE_W  = 2,
    localparam int NTYPES = 1 << TYPE_W,
    localparam int IW     = idx_width(N_SLOTS)
) (
    input  logic [N_SLOTS-1:0]        req,
    input  logic [N_SLOTS*TYPE_W-1:0] types,
    input  logic [NTYPES-1:0]         type_mask,
    input  logic                      avail,
    input  logic [N_SLOTS-1:0]        taken_in,
    output logic [N_SLOTS-1:0]        grant,
    output logic                      valid,
    output logic [IW-1:0]             index,
    output logic [N_SLOTS-1:0]        taken_out
);
    logic [N_SLOTS-1:0] eligible;

    // Mark slots this port may take this cycle.
    always_comb begin
        for (int s = 0; s < N_SLOTS; s++) begin
            eligible[s] = avail & req[s] & ~taken_in[s]
                        & type_mask[types[s*TYPE_W +: TYPE_W]];
        end
    end

    issel_prio_enc #(.WIDTH(N_SLOTS)) u_enc (
        .in_vec (eligible),
        .onehot (grant),
        .found  (valid),
        .index  (index)
    );

    // Add this port's pick to the claims seen by later ports.
    assign taken_out = taken_in | grant;
endmodule

// File: rtl/typed_issue_select.sv
// Module: multi-port typed issue selector (top). Chains one stage per port
// in fixed order; each stage excludes slots claimed by earlier stages.
// Assumes: purely combinational; the caller registers results as needed.
module typed_issue_select
    import typed_issue_select_pkg::*;
#(
    parameter int N_SLOTS = 8,
    parameter int N_PORTS = 3,
    parameter int TYPE_W  = 2,
    localparam int NTYPES = 1 << TYPE_W,
    localparam int IDX_W  = idx_width(N_SLOTS)
) (
    input  logic [N_SLOTS-1:0]        slot_req,
    input  logic [N_SLOTS*TYPE_W-1:0] slot_type,
    input  logic [N_PORTS*NTYPES-1:0] port_type_mask,
    input  logic [N_PORTS-1:0]        port_avail,
    output logic [N_PORTS*N_SLOTS-1:0] port_grant,
    output logic [N_PORTS-1:0]        port_valid,
    output logic [N_PORTS*IDX_W-1:0]  port_idx,
    output logic [N_SLOTS-1:0]        slot_issued
);
    logic [N_SLOTS-1:0] taken [N_PORTS+1];

    assign taken[0] = '0;

    // One cascade stage per port, port 0 at the head.
    for (genvar p = 0; p < N_PORTS; p++) begin : g_port
        issel_port_stage #(.N_SLOTS(N_SLOTS), .TYPE_W(TYPE_W)) u_stage (
            .req       (slot_req),
            .types     (slot_type),
            .type_mask (port_type_mask[p*NTYPES +: NTYPES]),
            .avail     (port_avail[p]),
            .taken_in  (taken[p]),
            .grant     (port_grant[p*N_SLOTS +: N_SLOTS]),
            .valid     (port_valid[p]),
            .index     (port_idx[p*IDX_W +: IDX_W]),
            .taken_out (taken[p+1])
        );
    end

    // Merged claims after the last port go back to the queue.
    assign slot_issued = taken[N_PORTS];
endmodule

// File: rtl/typed_issue_select_chk.sv
// Module: checker for the typed issue selector, bound to the top.
// Assumes: inputs are known; checks are skipped while any is X.
module typed_issue_select_chk
    import typed_issue_select_pkg::*;
#(
    parameter int N_SLOTS = 8,
    parameter int N_PORTS = 3,
    parameter int TYPE_W  = 2,
    localparam int NTYPES = 1 << TYPE_W,
    localparam int IDX_W  = idx_width(N_SLOTS)
) (
    input logic [N_SLOTS-1:0]         slot_req,
    input logic [N_SLOTS*TYPE_W-1:0]  slot_type,
    input logic [N_PORTS*NTYPES-1:0]  port_type_mask,
    input logic [N_PORTS-1:0]         port_avail,
    input logic [N_PORTS*N_SLOTS-1:0] port_grant,
    input logic [N_PORTS-1:0]         port_valid,
    input logic [N_PORTS*IDX_W-1:0]   port_idx,
    input logic [N_SLOTS-1:0]         slot_issued
);
    // Count ports claiming slot s.
    function automatic int claims(input int s);
        int c = 0;
        for (int p = 0; p < N_PORTS; p++) c += int'(port_grant[p*N_SLOTS + s]);
        return c;
    endfunction

    // Per-port and per-slot rules on the live outputs.
    always_comb begin
        if (!$isunknown({slot_req, slot_type, port_type_mask, port_avail})) begin
            for (int p = 0; p < N_PORTS; p++) begin
                assert_onehot_R1: assert ($onehot0(port_grant[p*N_SLOTS +: N_SLOTS])
                                  && (port_valid[p] == |port_grant[p*N_SLOTS +: N_SLOTS]));
                assert_avail_R5: assert (port_avail[p] || !port_valid[p]);
                for (int s = 0; s < N_SLOTS; s++) begin
                    if (port_grant[p*N_SLOTS + s]) begin
                        assert_req_R6: assert (slot_req[s]);
                        assert_type_R3: assert (port_type_mask[p*NTYPES +
                                                int'(slot_type[s*TYPE_W +: TYPE_W])]);
                        assert_index_R1: assert (int'(port_idx[p*IDX_W +: IDX_W]) == s);
                    end
                end
            end
            for (int s = 0; s < N_SLOTS; s++) begin
                assert_single_claim_R7: assert (claims(s) <= 1);
                assert_issued_R7: assert (slot_issued[s] == (claims(s) != 0));
            end
        end
    end
endmodule

bind typed_issue_select typed_issue_select_chk #(
    .N_SLOTS (N_SLOTS),
    .N_PORTS (N_PORTS),
    .TYPE_W  (TYPE_W)
) u_chk (
    .slot_req       (slot_req),
    .slot_type      (slot_type),
    .port_type_mask (port_type_mask),
    .port_avail     (port_avail),
    .port_grant     (port_grant),
    .port_valid     (port_valid),
    .port_idx       (port_idx),
    .slot_issued    (slot_issued)
);

// File: tb/typed_issue_select_bench.sv
// Scoreboard bench: driver pushes expected results, monitor pops and compares.
module typed_issue_select_bench;
    localparam int N  = 8;
    localparam int P  = 3;
    localparam int TW = 2;
    localparam int NT = 1 << TW;
    localparam int IW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic [N-1:0]    slot_req = '0;
    logic [N*TW-1:0] slot_type = '0;
    logic [P*NT-1:0] port_type_mask = '0;
    logic [P-1:0]    port_avail = '0;
    logic [P*N-1:0]  port_grant;
    logic [P-1:0]    port_valid;
    logic [P*IW-1:0] port_idx;
    logic [N-1:0]    slot_issued;

    typed_issue_select u_typed_issue_select (
        .slot_req, .slot_type, .port_type_mask, .port_avail,
        .port_grant, .port_valid, .port_idx, .slot_issued
    );

    typedef struct {
        logic [P*N-1:0]  g;
        logic [P-1:0]    v;
        logic [P*IW-1:0] ix;
        logic [N-1:0]    iss;
        string           tag;
    } exp_t;

    exp_t q[$];
    int total = 0;
    int bad = 0;
    bit done = 0;

    // Driver: apply inputs just after a rising edge and predict the outputs.
    task automatic drive(input logic [N-1:0] r, input logic [N*TW-1:0] t,
                         input logic [P*NT-1:0] m, input logic [P-1:0] a,
                         input string tag);
        exp_t e;
        logic [N-1:0] used = '0;
        @(posedge clk);
        #1;
        slot_req = r; slot_type = t; port_type_mask = m; port_avail = a;
        e.g = '0; e.v = '0; e.ix = '0; e.tag = tag;
        for (int p = 0; p < P; p++) begin
            if (a[p]) begin
                for (int s = 0; s < N; s++) begin
                    if (!e.v[p] && r[s] && !used[s] && m[p*NT + int'(t[s*TW +: TW])]) begin
                        e.v[p] = 1'b1;
                        e.g[p*N + s] = 1'b1;
                        e.ix[p*IW +: IW] = IW'(s);
                        used[s] = 1'b1;
                    end
                end
            end
        end
        e.iss = used;
        q.push_back(e);
    endtask

    // Monitor: R8, results are sampled on the falling edge of the same cycle.
    always @(negedge clk) begin
        if (rst_n && q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            total += 4;
            if (port_grant !== e.g) begin
                bad++; $display("FAIL %s grant act=%h exp=%h", e.tag, port_grant, e.g);
            end
            if (port_valid !== e.v) begin
                bad++; $display("FAIL %s R1 valid act=%b exp=%b", e.tag, port_valid, e.v);
            end
            if (port_idx !== e.ix) begin
                bad++; $display("FAIL %s R1 idx act=%h exp=%h", e.tag, port_idx, e.ix);
            end
            if (slot_issued !== e.iss) begin
                bad++; $display("FAIL %s R7 issued act=%b exp=%b", e.tag, slot_issued, e.iss);
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #2000000;
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    localparam logic [P*NT-1:0] ALL = '1;
    // Ports 0,1 take types 0..2 (integer-like); port 2 takes only type 3.
    localparam logic [P*NT-1:0] SPLIT = {4'b1000, 4'b0111, 4'b0111};

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // R9: idle reset state, nothing requested.
        drive('0, '0, ALL, '1, "R9_idle");
        // R4 / R2: everything eligible, ports take slots 0,1,2.
        drive('1, '0, ALL, '1, "R4_cascade");
        // R3: slot 0 is type 3, only port 2 takes it.
        drive(8'h0F, 16'h0003, SPLIT, '1, "R3_type");
        // R3: no slot carries type 3, port 2 idle.
        drive(8'hFF, '0, SPLIT, '1, "R3_no_match");
        // R5: port 0 busy, port 1 takes slot 0.
        drive(8'h03, '0, ALL, 3'b110, "R5_busy");
        // R5: all ports busy.
        drive('1, '0, ALL, '0, "R5_all_busy");
        // R2: sparse high-index requests.
        drive(8'hA0, '0, ALL, '1, "R2_sparse");
        // R6: no request, types match, nothing granted.
        drive(8'h00, {N{2'b11}}, SPLIT, '1, "R6_noreq");
        // R9: requests with types nobody accepts.
        drive(8'hFF, {N{2'b11}}, {4'b0001, 4'b0010, 4'b0100}, '1, "R9_none");
        // R4: single request shared by overlapping ports.
        drive(8'h80, '0, ALL, '1, "R4_single");
        // R7: random mixes.
        for (int i = 0; i < 300; i++) begin
            drive(N'($urandom), (N*TW)'($urandom), (P*NT)'($urandom),
                  P'($urandom), "R7_random");
        end
        repeat (3) @(posedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule